// File: doc/BRIEF.md
# Parallel Host Port with Strobe Framing

This block is the slave side of a byte-wide parallel port through which an external host moves 16-bit words to and from a processor core. The host frames each transfer with an active-low chip select and a data strobe. The strobe's active level is chosen by a configuration input. A direction line picks read or write, and a byte-select line picks the high or low half of the word. A full word therefore moves as two byte transfers.

The block holds one outbound word, which the core loads and the host reads, and one inbound word, which the host writes and the core takes. Two status pins tell the host when to act: an output-empty flag and an input-full flag. Each has a configurable output polarity. All host lines are brought into the system clock through a synchronizer chain. A transfer is recognised as the span during which both chip select and strobe are at their active levels.

Top module: `par_host_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the internal output-empty state is 1, the internal input-full state is 0, host_doe is 0 and core_rd_data is 0.
- R2: A transfer exists only while host_cs_n is 0 and host_stb is at its active level. Changing host_rw or host_bsel while no transfer exists drives no data, changes no flag and writes no register.
- R3: With cfg_stb_act_high = 1 the strobe is active when high. With 0 it is active when low.
- R4: During a read transfer (host_rw = 1), host_doe is 1 and host_dout carries bits 15:8 of the outbound word when host_bsel = 1, or bits 7:0 when host_bsel = 0.
- R5: A write transfer (host_rw = 0) stores the last byte seen on host_din into bits 15:8 of the inbound word when host_bsel = 1, or bits 7:0 when host_bsel = 0. The new value appears on core_rd_data once the transfer has ended.
- R6: Output-empty becomes 1 after a read transfer with host_bsel = 1 ends. A read transfer with host_bsel = 0 leaves it unchanged.
- R7: Input-full becomes 1 after a write transfer with host_bsel = 1 ends. A write transfer with host_bsel = 0 leaves it unchanged.
- R8: A cycle with core_wr_en = 1 loads core_wr_data into the outbound word and clears output-empty. This takes priority over a host read ending in the same cycle.
- R9: A cycle with core_rd_en = 1 clears input-full, unless a high-byte host write ends in the same cycle, in which case input-full is set.
- R10: host_obe equals output-empty XOR cfg_obe_invert. host_ibf equals input-full XOR cfg_ibf_invert.
- R11: A transfer ends as soon as either host_cs_n returns to 1 or the strobe returns to its inactive level, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host control pulses |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stb_act_high | input | 1 | Strobe polarity: 1 = active high, 0 = active low (static) |
| cfg_obe_invert | input | 1 | Invert the output-empty pin (static) |
| cfg_ibf_invert | input | 1 | Invert the input-full pin (static) |
| host_cs_n | input | 1 | Host chip select, active low |
| host_stb | input | 1 | Host data strobe, configurable polarity |
| host_rw | input | 1 | Direction: 1 = host reads, 0 = host writes |
| host_bsel | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| host_din | input | 8 | Byte from the host bus |
| host_dout | output | 8 | Byte to the host bus |
| host_doe | output | 1 | Enable for the external bus driver |
| host_obe | output | 1 | Output-empty flag pin |
| host_ibf | output | 1 | Input-full flag pin |
| core_wr_en | input | 1 | Core loads an outbound word |
| core_wr_data | input | 16 | Outbound word from the core |
| core_rd_en | input | 1 | Core takes the inbound word |
| core_rd_data | output | 16 | Inbound word to the core |

## Verification
The bench builds the block with its defaults: a byte width of 8 and a two-stage synchronizer. This places a host edge's effect two clock edges after the edge on the pins, and flag updates three edges after a transfer closes. The waits in the bench are sized from these figures. The strobe and flag polarities are ports rather than parameters, so one build covers both strobe levels, both ways of closing a transfer and both flag polarities.

// File: rtl/hp_pkg.sv
// Shared types for the parallel host port.
// Assumes a two-lane (high/low byte) word, selected by one byte-select bit.
package hp_pkg;
    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } hp_dir_e;

    // Attributes of the transfer currently open (or last open).
    typedef struct packed {
        hp_dir_e dir;
        logic    hi;
    } hp_txn_t;
endpackage

// File: rtl/hp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous host lines.
// Assumes every line holds its level well beyond STAGES clock periods.
module hp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift each line through the chain; reset loads the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hp_frame.sv
// Transfer framing: a transfer is open while chip select and strobe are both
// active, and closes when either drops. Direction is only recorded, never used
// to frame. Assumes synchronized inputs and static strobe polarity.
module hp_frame
    import hp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb_act_high,
    input  logic              cs_n_s,
    input  logic              stb_s,
    input  logic              rw_s,
    input  logic              bsel_s,
    input  logic [BYTE_W-1:0] din_s,
    output logic              sel,
    output logic              close,
    output hp_txn_t           txn,
    output logic [BYTE_W-1:0] txn_byte
);
    logic sel_q;

    assign sel   = !cs_n_s && (stb_s == cfg_stb_act_high);
    assign close = sel_q && !sel;

    // Remember whether a transfer was open on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    // While open, track direction, byte lane and the latest host byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn      <= '{dir: XFER_WRITE, hi: 1'b0};
            txn_byte <= '0;
        end else if (sel) begin
            txn      <= '{dir: hp_dir_e'(rw_s), hi: bsel_s};
            txn_byte <= din_s;
        end
    end

    // R11: a close pulse is a single cycle and is followed by a closed frame
    assert_close_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> !close);
endmodule

// File: rtl/hp_regs.sv
// Word registers and handshake flags. The host fills the inbound word one
// byte lane at a time; flags move only when a high-byte transfer ends or the
// core acts. Assumes close is a single-cycle pulse with txn held stable.
module hp_regs
    import hp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LANES  = 2,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close,
    input  hp_txn_t           txn,
    input  logic [BYTE_W-1:0] txn_byte,
    input  logic              core_wr_en,
    input  logic [WORD_W-1:0] core_wr_data,
    input  logic              core_rd_en,
    output logic [WORD_W-1:0] out_word,
    output logic [WORD_W-1:0] in_word,
    output logic              obe,
    output logic              ibf
);
    logic host_wr_done;
    logic host_rd_done;

    assign host_wr_done = close && (txn.dir == XFER_WRITE);
    assign host_rd_done = close && (txn.dir == XFER_READ);

    // One register per inbound byte lane, written when its lane's write ends.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic LANE_HI = (g == LANES - 1);
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_word[g*BYTE_W +: BYTE_W] <= '0;
            else if (host_wr_done && (txn.hi == LANE_HI))
                in_word[g*BYTE_W +: BYTE_W] <= txn_byte;
        end
    end

    // Outbound word is loaded by the core only.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_word <= '0;
        else if (core_wr_en) out_word <= core_wr_data;
    end

    // Output-empty: set by a finished high-byte read, cleared by a core load.
    always_ff @(posedge clk) begin
        if (!rst_n)                       obe <= 1'b1;
        else if (core_wr_en)              obe <= 1'b0;
        else if (host_rd_done && txn.hi)  obe <= 1'b1;
    end

    // Input-full: set by a finished high-byte write, cleared by a core take.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ibf <= 1'b0;
        else if (host_wr_done && txn.hi)  ibf <= 1'b1;
        else if (core_rd_en)              ibf <= 1'b0;
    end

    // R6: a finished high-byte read marks the output word empty
    assert_obe_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_done && txn.hi && !core_wr_en) |=> obe);
    // R6: without a read end or core load, output-empty holds
    assert_obe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_done && !core_wr_en) |=> $stable(obe));
    // R8: a core load always empties the flag
    assert_obe_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_en |=> !obe);
    // R7: a finished high-byte write marks the input word full
    assert_ibf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_done && txn.hi) |=> ibf);
    // R9: a core take with no concurrent high-byte write clears input-full
    assert_ibf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_en && !(host_wr_done && txn.hi)) |=> !ibf);
    // R5: the inbound word changes only when a host write ends
    assert_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_done |=> $stable(in_word));
endmodule

// File: rtl/par_host_port.sv
// Byte-wide slave host port carrying 16-bit words in two byte transfers.
// Synchronizes the host lines, frames transfers from chip select and strobe,
// drives read data and applies the flag polarities. Assumes configuration
// inputs only change while no transfer is open.
module par_host_port #(
    parameter int BYTE_W    = 8,
    parameter int SYNC_DEPTH = 2,
    localparam int WORD_W   = 2 * BYTE_W,
    localparam int SYNC_W   = 4 + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb_act_high,
    input  logic              cfg_obe_invert,
    input  logic              cfg_ibf_invert,
    input  logic              host_cs_n,
    input  logic              host_stb,
    input  logic              host_rw,
    input  logic              host_bsel,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_obe,
    output logic              host_ibf,
    input  logic              core_wr_en,
    input  logic [WORD_W-1:0] core_wr_data,
    input  logic              core_rd_en,
    output logic [WORD_W-1:0] core_rd_data
);
    import hp_pkg::*;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              cs_n_s, stb_s, rw_s, bsel_s;
    logic [BYTE_W-1:0] din_s;
    logic              sel, close;
    hp_txn_t           txn;
    logic [BYTE_W-1:0] txn_byte;
    logic [WORD_W-1:0] out_word;
    logic              obe, ibf;

    assign raw_bus = {host_cs_n, host_stb, host_rw, host_bsel, host_din};

    hp_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL ({1'b1, {(SYNC_W-1){1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    assign {cs_n_s, stb_s, rw_s, bsel_s, din_s} = sync_bus;

    hp_frame #(.BYTE_W(BYTE_W)) u_frame (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_stb_act_high (cfg_stb_act_high),
        .cs_n_s           (cs_n_s),
        .stb_s            (stb_s),
        .rw_s             (rw_s),
        .bsel_s           (bsel_s),
        .din_s            (din_s),
        .sel              (sel),
        .close            (close),
        .txn              (txn),
        .txn_byte         (txn_byte)
    );

    hp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .close        (close),
        .txn          (txn),
        .txn_byte     (txn_byte),
        .core_wr_en   (core_wr_en),
        .core_wr_data (core_wr_data),
        .core_rd_en   (core_rd_en),
        .out_word     (out_word),
        .in_word      (core_rd_data),
        .obe          (obe),
        .ibf          (ibf)
    );

    // Read path: drive the selected half while a read transfer is open.
    always_comb begin
        host_doe  = sel && rw_s;
        host_dout = bsel_s ? out_word[WORD_W-1 -: BYTE_W] : out_word[BYTE_W-1:0];
    end

    // Flag pins carry the configured polarity.
    assign host_obe = obe ^ cfg_obe_invert;
    assign host_ibf = ibf ^ cfg_ibf_invert;

    // R2: the bus driver is never enabled while the host is deselected
    assert_no_drive_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !host_doe);
endmodule

// File: tb/tb_par_host_port.sv
module tb_par_host_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_stb_act_high, cfg_obe_invert, cfg_ibf_invert;
    logic        host_cs_n, host_stb, host_rw, host_bsel;
    logic [7:0]  host_din, host_dout;
    logic        host_doe, host_obe, host_ibf;
    logic        core_wr_en, core_rd_en;
    logic [15:0] core_wr_data, core_rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    par_host_port dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_stb_act_high(cfg_stb_act_high),
        .cfg_obe_invert(cfg_obe_invert), .cfg_ibf_invert(cfg_ibf_invert),
        .host_cs_n(host_cs_n), .host_stb(host_stb), .host_rw(host_rw),
        .host_bsel(host_bsel), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .host_obe(host_obe), .host_ibf(host_ibf),
        .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
        .core_rd_en(core_rd_en), .core_rd_data(core_rd_data)
    );

    // Vector: {rd, hi, strobe_high(R3), byte, exp_dout, exp_obe, exp_ibf, exp_in}
    localparam logic [36:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h96, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h3C, 1'b1, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b1, 1'b0, 16'h005A},
        {1'b0, 1'b1, 1'b1, 8'hC3, 8'h00, 1'b1, 1'b1, 16'hC35A},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h96, 1'b1, 1'b1, 16'hC35A},
        {1'b0, 1'b0, 1'b0, 8'h11, 8'h00, 1'b1, 1'b1, 16'hC311}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_xfer(input logic rd, input logic hi, input logic pol,
                             input logic [7:0] b, input logic close_by_cs,
                             output logic [7:0] seen, output logic seen_oe);
        @(negedge clk);
        cfg_stb_act_high = pol; host_stb = !pol; host_cs_n = 1'b1;
        host_rw = rd; host_bsel = hi; host_din = b;
        repeat (3) @(negedge clk);
        host_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        host_stb = pol;
        repeat (4) @(negedge clk);
        seen = host_dout; seen_oe = host_doe;
        if (close_by_cs) host_cs_n = 1'b1; else host_stb = !pol;
        repeat (5) @(negedge clk);
        host_cs_n = 1'b1; host_stb = !pol;
        repeat (3) @(negedge clk);
    endtask

    task automatic core_load(input logic [15:0] v);
        @(negedge clk); core_wr_en = 1'b1; core_wr_data = v;
        @(negedge clk); core_wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic core_take();
        @(negedge clk); core_rd_en = 1'b1;
        @(negedge clk); core_rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] seen;
        logic       oe;
        rst_n = 1'b0;
        cfg_stb_act_high = 1'b0; cfg_obe_invert = 1'b0; cfg_ibf_invert = 1'b0;
        host_cs_n = 1'b1; host_stb = 1'b1; host_rw = 1'b0; host_bsel = 1'b0;
        host_din = 8'h00; core_wr_en = 1'b0; core_rd_en = 1'b0; core_wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 obe", host_obe, 16'd1);
        chk("R1 ibf", host_ibf, 16'd0);
        chk("R1 doe", host_doe, 16'd0);
        chk("R1 core_rd_data", core_rd_data, 16'h0000);

        core_load(16'h3C96);
        chk("R8 obe cleared by load", host_obe, 16'd0);

        // Table walk: reads, writes, both lanes, both strobe polarities
        for (int i = 0; i < 6; i++) begin
            host_xfer(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:26], 1'b0, seen, oe);
            if (VEC[i][36]) begin
                chk("R4 dout", seen, VEC[i][25:18]);
                chk("R3/R4 doe during read", oe, 16'd1);
            end else begin
                chk("R4 no drive on write", oe, 16'd0);
            end
            chk("R6 obe", host_obe, VEC[i][17]);
            chk("R7 ibf", host_ibf, VEC[i][16]);
            chk("R5 inbound word", core_rd_data, VEC[i][15:0]);
        end

        // R9: core take clears input-full
        core_take();
        chk("R9 ibf cleared", host_ibf, 16'd0);

        // R8: new outbound word replaces old and clears empty
        core_load(16'hBEEF);
        chk("R8 obe cleared", host_obe, 16'd0);
        host_xfer(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, seen, oe);
        chk("R8 new high byte read", seen, 16'h00BE);
        chk("R6 obe set after high read", host_obe, 16'd1);

        // R2: direction and byte-select toggles without a frame do nothing
        @(negedge clk);
        cfg_stb_act_high = 1'b0; host_cs_n = 1'b1; host_stb = 1'b0; host_din = 8'hEE;
        for (int k = 0; k < 8; k++) begin
            host_rw = k[0]; host_bsel = k[1];
            repeat (3) @(negedge clk);
            chk("R2 no drive, cs inactive", host_doe, 16'd0);
        end
        host_cs_n = 1'b0; host_stb = 1'b1;  // selected chip, strobe inactive
        for (int k = 0; k < 4; k++) begin
            host_rw = k[0]; host_bsel = k[1];
            repeat (3) @(negedge clk);
            chk("R2 no drive, strobe inactive", host_doe, 16'd0);
        end
        host_cs_n = 1'b1; host_rw = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 obe unchanged", host_obe, 16'd1);
        chk("R2 ibf unchanged", host_ibf, 16'd0);
        chk("R2 inbound unchanged", core_rd_data, 16'hC311);

        // R11: transfer closed by chip select while strobe still active
        host_xfer(1'b0, 1'b1, 1'b1, 8'h77, 1'b1, seen, oe);
        chk("R11 write committed on cs close", core_rd_data, 16'h7711);
        chk("R11 ibf set on cs close", host_ibf, 16'd1);

        // R10: inverted flag pins
        @(negedge clk);
        cfg_obe_invert = 1'b1; cfg_ibf_invert = 1'b1;
        @(negedge clk);
        chk("R10 obe inverted", host_obe, 16'd0);
        chk("R10 ibf inverted", host_ibf, 16'd0);
        core_take();
        chk("R10 ibf inverted after take", host_ibf, 16'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule